// File: doc/BRIEF.md
# Static Memory Wait-State Controller

This block times accesses to one chip-select region of an external static memory such as an SRAM or a parallel flash. A 16-bit control word sets three phases of every access. The first is a setup delay that holds the write strobe off after chip-select goes low. It applies to writes only. The second is a run of active wait states, used by both reads and writes. The third is a run of trailing idle cycles before the next access may begin.

A requester presents an address, a read/write flag and write data, and the request is taken while `ready` is high. The controller drives the chip-select, output-enable and write-enable strobes. It holds the address and the write data steady for the whole selected window. For a read it returns the captured data together with a one-cycle `done` pulse; a write gives the same pulse. The control word can be read back at any time. A write to it takes effect only while the privilege input is high. The control word sampled when a request is accepted governs that whole access.

Top module: `sram_wait_ctrl`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0 and all timing fields of the control word read back as 0.
- R2: A control write with `cfg_priv` high loads the timing fields. Read-back layout: bits 13:12 hold the write setup delay (0–3), bits 11:9 the trailing idle count (0–7), bits 7:4 the active wait count (0–15), and bit 3 mirrors the `endian_le` pin (1 = little endian).
- R3: A control write with `cfg_priv` low leaves every field of the control word unchanged.
- R4: Bits 15:14, 8, 2, 1 and 0 of the read-back always read 0, whatever value was written.
- R5: A write access pulls `mem_cs_n` low. `mem_we_n` stays high for LEAD cycles, then goes low for 1 + ACTIVE cycles, and then returns high in the same cycle as `mem_cs_n`.
- R6: A read access pulls `mem_cs_n` and `mem_oe_n` low in the same cycle, with no setup delay. Both stay low for 1 + ACTIVE cycles, and `mem_we_n` stays high throughout.
- R7: A read captures `mem_din` on its last active cycle. `done` is high for exactly one cycle, the one after the last active cycle, for reads and writes alike, and `rd_data` holds the captured word from that cycle on.
- R8: After `mem_cs_n` returns high, `ready` stays low for TRAIL further cycles and then rises.
- R9: `req_valid` asserted while `ready` is low starts no access and is not queued.
- R10: A privileged control write made during an access leaves that access's timing unchanged, and the next access uses the new values.
- R11: While `mem_cs_n` is low, `mem_addr` holds the accepted address. During a write, `mem_dout_en` is high and `mem_dout` holds the accepted write data. `mem_dout_en` is never high outside a write window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_priv | input | 1 | Privilege qualifier for control writes |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read-back |
| endian_le | input | 1 | Static byte-order strap, reflected in bit 3 |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Data returned by memory |

## Verification
The hardest situation to reach from the ports is a control word change that lands in the middle of an access. The old and new timings must then be told apart in two consecutive accesses. The bench issues a privileged control write on the first busy cycle of an access and measures the phase lengths of that access and of the next one. It also holds `req_valid` high through every busy cycle of an access with a long trailing window. It then confirms that chip-select stays high once the controller falls idle.

// File: rtl/swc_pkg.sv
// Shared definitions for the static memory wait-state controller.
// Assumes a 16-bit control word; field positions are fixed because
// software decodes them.
package swc_pkg;
    localparam int CFG_W      = 16;
    localparam int LEAD_W     = 2;
    localparam int TRAIL_W    = 3;
    localparam int ACT_W      = 4;
    localparam int LEAD_LSB   = 12;
    localparam int TRAIL_LSB  = 9;
    localparam int ACT_LSB    = 4;
    localparam int ENDIAN_BIT = 3;

    // Counter wide enough for the largest phase field
    localparam int CNT_W = (ACT_W >= TRAIL_W && ACT_W >= LEAD_W) ? ACT_W :
                           (TRAIL_W >= LEAD_W) ? TRAIL_W : LEAD_W;

    // Build a contiguous mask of w bits starting at lsb
    function automatic logic [CFG_W-1:0] field_mask(input int lsb, input int w);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    localparam logic [CFG_W-1:0] WR_MASK = field_mask(LEAD_LSB, LEAD_W)
                                         | field_mask(TRAIL_LSB, TRAIL_W)
                                         | field_mask(ACT_LSB, ACT_W);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_TRAIL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [LEAD_W-1:0]  lead;
        logic [TRAIL_W-1:0] trail;
        logic [ACT_W-1:0]   active;
    } timing_t;
endpackage

// File: rtl/swc_cfg_reg.sv
// Control word storage. Holds only the writable timing fields; reserved
// bits are never stored, so they read as zero. A write lands only when
// the privilege qualifier is high. Assumes full 16-bit writes.
module swc_cfg_reg
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             priv,
    input  logic [CFG_W-1:0] wdata,
    input  logic             endian_le,
    output logic [CFG_W-1:0] rdata,
    output timing_t          timing_o
);
    logic [CFG_W-1:0] word_q;

    // Store the writable fields of a privileged write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en && priv) begin
            word_q <= wdata & WR_MASK;
        end
    end

    // Read-back: stored fields plus the live byte-order strap
    always_comb begin
        rdata = word_q | (CFG_W'(endian_le) << ENDIAN_BIT);
    end

    // Split the stored word into its timing fields
    always_comb begin
        timing_o.lead   = word_q[LEAD_LSB  +: LEAD_W];
        timing_o.trail  = word_q[TRAIL_LSB +: TRAIL_W];
        timing_o.active = word_q[ACT_LSB   +: ACT_W];
    end
endmodule

// File: rtl/swc_seq.sv
// Phase sequencer. On start it snapshots the active and trailing counts
// so that control writes during an access affect only later accesses.
// Setup delay applies to writes only. Assumes start is asserted only
// while idle.
module swc_seq
    import swc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    start_write,
    input  timing_t timing_i,
    output phase_e  phase_o,
    output logic    last_active_o,
    output logic    idle_o
);
    phase_e             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [ACT_W-1:0]   act_q;
    logic [TRAIL_W-1:0] trail_q;

    // Snapshot active and trailing counts at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            trail_q <= '0;
        end else if (start) begin
            act_q   <= timing_i.active;
            trail_q <= timing_i.trail;
        end
    end

    // Next phase and remaining-cycle count
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    if (start_write && timing_i.lead != '0) begin
                        phase_d = PH_LEAD;
                        cnt_d   = CNT_W'(timing_i.lead) - CNT_W'(1);
                    end else begin
                        phase_d = PH_ACTIVE;
                        cnt_d   = CNT_W'(timing_i.active);
                    end
                end
            end
            PH_LEAD: begin
                if (cnt_q == '0) begin
                    phase_d = PH_ACTIVE;
                    cnt_d   = CNT_W'(act_q);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (cnt_q == '0) begin
                    if (trail_q != '0) begin
                        phase_d = PH_TRAIL;
                        cnt_d   = CNT_W'(trail_q) - CNT_W'(1);
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_TRAIL: begin
                if (cnt_q == '0) phase_d = PH_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase_o       = phase_q;
    assign last_active_o = (phase_q == PH_ACTIVE) && (cnt_q == '0);
    assign idle_o        = (phase_q == PH_IDLE);
endmodule

// File: rtl/swc_datapath.sv
// Address and data path plus strobe decode. Latches the request on
// start, drives it for the whole selected window, captures read data
// on the last active cycle and raises done for one cycle afterwards.
// Assumes phase comes from registers, so the strobes are glitch-free.
module swc_datapath
    import swc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase_i,
    input  logic              last_active_i,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              selected;

    // Hold the accepted request for the duration of the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    // Capture read data on the last active cycle and flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (last_active_i && !wr_q) rdata_q <= mem_din;
            done_q <= last_active_i;
        end
    end

    // Strobe decode from the current phase
    always_comb begin
        selected    = (phase_i == PH_LEAD) || (phase_i == PH_ACTIVE);
        mem_cs_n    = !selected;
        mem_oe_n    = !((phase_i == PH_ACTIVE) && !wr_q);
        mem_we_n    = !((phase_i == PH_ACTIVE) && wr_q);
        mem_dout_en = selected && wr_q;
    end

    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;
    assign rd_data  = rdata_q;
    assign done     = done_q;
endmodule

// File: rtl/sram_wait_ctrl.sv
// Top of the static memory wait-state controller for one chip-select
// region. Accepts a request while ready, runs setup / active / trailing
// phases from the control word, returns read data with a done pulse.
// Assumes the requester drops req_valid once the request is taken.
module sram_wait_ctrl
    import swc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_priv,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              endian_le,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    timing_t timing;
    phase_e  phase;
    logic    last_active;
    logic    idle;
    logic    start;

    // Accept a request only while idle
    assign start = req_valid && idle;
    assign ready = idle;

    swc_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .priv      (cfg_priv),
        .wdata     (cfg_wdata),
        .endian_le (endian_le),
        .rdata     (cfg_rdata),
        .timing_o  (timing)
    );

    swc_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_write   (req_write),
        .timing_i      (timing),
        .phase_o       (phase),
        .last_active_o (last_active),
        .idle_o        (idle)
    );

    swc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .phase_i       (phase),
        .last_active_i (last_active),
        .mem_din       (mem_din),
        .mem_addr      (mem_addr),
        .mem_dout      (mem_dout),
        .mem_dout_en   (mem_dout_en),
        .mem_cs_n      (mem_cs_n),
        .mem_oe_n      (mem_oe_n),
        .mem_we_n      (mem_we_n),
        .rd_data       (rd_data),
        .done          (done)
    );
endmodule

// File: rtl/swc_checker.sv
// Protocol checks on the controller's ports, bound to the top module.
module swc_checker
    import swc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              cfg_priv,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              ready,
    input logic              done,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    localparam logic [CFG_W-1:0] NO_STRAP = ~(CFG_W'(1) << ENDIAN_BIT);
    localparam logic [CFG_W-1:0] RSVD     = ~WR_MASK & NO_STRAP;

    assert_priv_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_priv) |=> $stable(cfg_rdata & NO_STRAP));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & RSVD) == '0);

    assert_we_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    assert_oe_we_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_read_no_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $fell(mem_cs_n));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_when_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !ready);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    assert_drive_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (!mem_cs_n && mem_oe_n));
endmodule

bind sram_wait_ctrl swc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_swc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_priv    (cfg_priv),
    .cfg_rdata   (cfg_rdata),
    .ready       (ready),
    .done        (done),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/tb_sram_wait_ctrl.sv
module tb_sram_wait_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0, cfg_priv = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          endian_le = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, done;
    logic [DW-1:0] rd_data;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din;

    int n_chk = 0;
    int n_fail = 0;

    sram_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_priv(cfg_priv),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .endian_le(endian_le),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rd_data(rd_data),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: returns a word derived from the address while enabled
    assign mem_din = mem_oe_n ? '0 : (mem_addr ^ 16'hA5C3);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int l, input int t, input int a);
        return 16'((l << 12) | (t << 9) | (a << 4));
    endfunction

    task automatic cfg_write(input logic [15:0] v, input logic p);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_priv = p; cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_priv = 1'b0;
    endtask

    // One access, measured phase by phase; optional busy poke and mid-access cfg write
    task automatic access(input string tag, input logic wr, input logic [15:0] addr,
                          input logic [15:0] data, input int el, input int ea, input int et,
                          input bit poke, input bit mid, input logic [15:0] mid_val);
        int n_lead = 0, n_act = 0, n_trail = 0, n_done = 0, n_bad = 0, n_wrong = 0;
        logic [15:0] got = '0, wa = '0, wd = '0;
        @(negedge clk);
        chk({tag, " R9 ready before request"}, 32'(ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            req_valid = poke;
            req_addr  = addr + 16'h0100;
            cfg_wr_en = mid && (i == 0);
            cfg_priv  = mid && (i == 0);
            cfg_wdata = mid_val;
            if (done) begin n_done++; got = rd_data; end
            if (ready) begin req_valid = 1'b0; break; end
            if (!mem_cs_n) begin
                if (mem_addr !== addr) n_bad++;
                if (wr && (!mem_dout_en || mem_dout !== data)) n_bad++;
                if (!wr && mem_dout_en) n_bad++;
                if ((wr && !mem_oe_n) || (!wr && !mem_we_n)) n_wrong++;
                if (!mem_we_n) begin wa = mem_addr; wd = mem_dout; end
                if (!mem_we_n || !mem_oe_n) n_act++;
                else n_lead++;
            end else begin
                n_trail++;
            end
        end
        cfg_wr_en = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
        chk({tag, wr ? " R5 setup cycles" : " R6 no setup"}, 32'(n_lead), 32'(wr ? el : 0));
        chk({tag, wr ? " R5 write strobe cycles" : " R6 read strobe cycles"}, 32'(n_act), 32'(1 + ea));
        chk({tag, " R6 wrong strobe"}, 32'(n_wrong), 32'd0);
        chk({tag, " R8 trailing cycles"}, 32'(n_trail), 32'(et));
        chk({tag, " R7 done pulses"}, 32'(n_done), 32'd1);
        chk({tag, " R11 address/data hold"}, 32'(n_bad), 32'd0);
        if (wr) begin
            chk({tag, " R5 written addr"}, 32'(wa), 32'(addr));
            chk({tag, " R5 written data"}, 32'(wd), 32'(data));
        end else begin
            chk({tag, " R7 read data"}, 32'(got), 32'(addr ^ 16'hA5C3));
            @(negedge clk);
            chk({tag, " R7 read data held"}, 32'(rd_data), 32'(addr ^ 16'hA5C3));
        end
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk({tag, " R9 no access from busy request"}, 32'(mem_cs_n), 32'd1);
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 strobes", 32'({mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}), 32'b1110);
        chk("R1 control word", 32'(cfg_rdata), 32'h0);
    endtask

    task automatic test_register();
        cfg_write(16'hFFFF, 1'b1);
        chk("R2 R4 all-ones write", 32'(cfg_rdata), 32'h3EF0);
        cfg_write(16'h2A5A, 1'b1);
        chk("R2 field write", 32'(cfg_rdata), 32'h2A50);
        endian_le = 1'b1;
        #1;
        chk("R2 endian strap", 32'(cfg_rdata), 32'h2A58);
        endian_le = 1'b0;
        cfg_write(16'h1234, 1'b0);
        chk("R3 unprivileged write", 32'(cfg_rdata), 32'h2A50);
    endtask

    task automatic test_min();
        cfg_write(16'h0000, 1'b1);
        access("min-write", 1'b1, 16'h1357, 16'hBEEF, 0, 0, 0, 0, 0, '0);
        access("min-read", 1'b0, 16'h2468, '0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic test_mid();
        cfg_write(mk(3, 1, 2), 1'b1);
        access("mid-write", 1'b1, 16'h0F0F, 16'h5A5A, 3, 2, 1, 0, 0, '0);
        access("mid-read", 1'b0, 16'h0F10, '0, 3, 2, 1, 0, 0, '0);
    endtask

    task automatic test_max();
        cfg_write(mk(3, 7, 15), 1'b1);
        access("max-write", 1'b1, 16'hFFFF, 16'h0001, 3, 15, 7, 0, 0, '0);
        access("max-read", 1'b0, 16'h8000, '0, 3, 15, 7, 0, 0, '0);
    endtask

    task automatic test_busy_request();
        cfg_write(mk(0, 7, 0), 1'b1);
        access("busy-poke R9", 1'b0, 16'h4321, '0, 0, 0, 7, 1, 0, '0);
    endtask

    task automatic test_change_during_access();
        cfg_write(mk(1, 1, 1), 1'b1);
        access("R10 old timing", 1'b1, 16'h00AA, 16'hC0DE, 1, 1, 1, 0, 1, mk(2, 2, 3));
        chk("R10 new word stored", 32'(cfg_rdata), 32'(mk(2, 2, 3)));
        access("R10 new timing", 1'b1, 16'h00AB, 16'hC0DF, 2, 3, 2, 0, 0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_register();
        test_min();
        test_mid();
        test_max();
        test_busy_request();
        test_change_during_access();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule